// File: doc/BRIEF.md
# Age-Ordered Issue Scheduler

This block is the scheduling buffer of an out-of-order core. Decoded instructions enter with two source operand tags, one availability bit per source, a resource group and an execution latency. An entry whose sources are all available becomes eligible for issue. Otherwise it waits until the matching result tags arrive on the wakeup bus.

Every cycle the scheduler picks eligible entries, oldest first, up to a fixed issue width. Each pick gets one idle execution unit from its group. A round-robin pointer per group spreads the work over the units of that group. An issued entry holds its unit until its latency runs out. In that cycle the block raises a write-back flag for the entry, and the slot and the unit are freed at the next edge.

Operand values, register renaming and retirement are handled elsewhere. A parent block takes the write-back flags and forwards result tags to the wakeup bus.

Top module: `issue_sched`

## Requirements
- R1: After reset the buffer is empty. `dispReady` is 1, and `issueValid` and `wbMask` are all zero.
- R2: While a slot is free, `dispReady` is 1 and `dispIdx` names the lowest-numbered free slot. A dispatch with `dispValid` high takes that slot. When all slots are full, `dispReady` is 0 and a dispatch request is ignored.
- R3: An instruction dispatched with all source bits set can issue from the cycle after dispatch. One dispatched with a clear source bit cannot issue until that source is woken.
- R4: A wakeup (`wakeValid` with `wakeTag`) marks every matching source of waiting entries as available. An entry whose sources are all available can issue from the next cycle. A wakeup in the same cycle as a dispatch also applies to the instruction being dispatched.
- R5: Among entries that can issue, older dispatches are picked before younger ones. Age is compared as the difference of wrapping sequence numbers. Slot 0 of the issue outputs carries the oldest pick.
- R6: Global unit number = group × UNITS_PER_GRP + index in group. Each group starts its search at its pointer and takes the first idle unit at or after the pointer, wrapping around the group. After a grant the pointer moves to the unit after the one granted. A unit is busy from the cycle after its issue up to and including its write-back cycle.
- R7: An eligible entry whose group has no idle unit stays eligible without issuing. Younger entries of other groups may issue in its place.
- R8: At most ISSUE_W instructions issue per cycle.
- R9: An entry issued in cycle t with latency L (1 to 2^LAT_W−1) raises its `wbMask` bit in cycle t+L only. The slot is free again in cycle t+L+1.
- R10: An entry may issue before older entries that are still waiting for operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispTags | input | SRCS*TAG_W | Source tags, source s at bits s*TAG_W |
| dispSrcRdy | input | SRCS | Source already available, one bit per source |
| dispGrp | input | GRP_W | Resource group requested |
| dispLat | input | LAT_W | Execution latency in cycles, at least 1 |
| wakeValid | input | 1 | Result broadcast valid |
| wakeTag | input | TAG_W | Result broadcast tag |
| dispReady | output | 1 | A slot is free |
| dispIdx | output | IDX_W | Slot a dispatch this cycle takes |
| issueValid | output | ISSUE_W | Issue slot used |
| issueIdx | output | ISSUE_W*IDX_W | Entry issued per slot |
| issueUnit | output | ISSUE_W*UNIT_W | Global unit granted per slot |
| wbMask | output | ENTRIES | Entries writing back this cycle |

## Verification
The bench fills the buffer with instructions that are never woken. A block that miscounts free slots would accept a ninth dispatch or overwrite a live entry. A burst of ready instructions to a single group checks that entries stall and keep their age order while both units are busy. A scheduler that ignored busy units would hand one unit to two instructions. A round-robin pointer that failed to advance would always favour unit 0. Long random runs bring in same-cycle wakeups at dispatch and the wrap of the sequence counter. A missing dispatch-time wakeup leaves an entry stuck waiting. A wrong age compare shows up as an out-of-order pick once the counter wraps.

// File: rtl/issq_pkg.sv
package issq_pkg;
  parameter int ENTRIES       = 8;
  parameter int SRCS          = 2;
  parameter int TAG_W         = 4;
  parameter int GROUPS        = 2;
  parameter int UNITS_PER_GRP = 2;
  parameter int ISSUE_W       = 2;
  parameter int LAT_W         = 3;
  parameter int SEQ_W         = 6;

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int UPG_W  = (UNITS_PER_GRP > 1) ? $clog2(UNITS_PER_GRP) : 1;
  localparam int UNITS  = GROUPS * UNITS_PER_GRP;
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_READY = 2'd1,
    ST_EXEC  = 2'd2
  } entState_t;

  typedef struct packed {
    logic                            dispFire;
    logic [IDX_W-1:0]                allocIdx;
    logic [ENTRIES-1:0]              issueMask;
    logic [ENTRIES-1:0][UNIT_W-1:0]  issueUnit;
  } strobes_t;
endpackage

// File: rtl/issq_entries.sv
module issq_entries
  import issq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobes_t                       strb,
  input  logic [SRCS-1:0][TAG_W-1:0]     dispTag,
  input  logic [SRCS-1:0]                dispRdy,
  input  logic [GRP_W-1:0]               dispGrp,
  input  logic [LAT_W-1:0]               dispLat,
  input  logic [SEQ_W-1:0]               dispSeq,
  input  logic                           wakeValid,
  input  logic [TAG_W-1:0]               wakeTag,
  output logic [ENTRIES-1:0]             validMask,
  output logic [ENTRIES-1:0]             readyMask,
  output logic [ENTRIES-1:0]             execMask,
  output logic [ENTRIES-1:0]             doneMask,
  output logic [ENTRIES-1:0][GRP_W-1:0]  grpOf,
  output logic [ENTRIES-1:0][SEQ_W-1:0]  seqOf,
  output logic [ENTRIES-1:0][UNIT_W-1:0] unitOf
);
  logic      [ENTRIES-1:0]                       vld;
  entState_t                                     st [ENTRIES];
  logic      [ENTRIES-1:0][SRCS-1:0][TAG_W-1:0]  srcTag;
  logic      [ENTRIES-1:0][SRCS-1:0]             srcRdy;
  logic      [ENTRIES-1:0][SRCS-1:0]             rdyNow;
  logic      [ENTRIES-1:0][LAT_W-1:0]            lat;
  logic      [ENTRIES-1:0][LAT_W-1:0]            cnt;
  logic      [SRCS-1:0]                          dispRdyW;

  // wakeup applied to stored sources and to the incoming instruction
  always_comb begin
    for (int e = 0; e < ENTRIES; e++)
      for (int s = 0; s < SRCS; s++)
        rdyNow[e][s] = srcRdy[e][s] | (wakeValid && (srcTag[e][s] == wakeTag));
    for (int s = 0; s < SRCS; s++)
      dispRdyW[s] = dispRdy[s] | (wakeValid && (dispTag[s] == wakeTag));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld    <= '0;
      srcTag <= '0;
      srcRdy <= '0;
      lat    <= '0;
      cnt    <= '0;
      grpOf  <= '0;
      seqOf  <= '0;
      unitOf <= '0;
      for (int e = 0; e < ENTRIES; e++) st[e] <= ST_WAIT;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (strb.dispFire && (strb.allocIdx == IDX_W'(e))) begin
          vld[e]    <= 1'b1;
          srcTag[e] <= dispTag;
          srcRdy[e] <= dispRdyW;
          grpOf[e]  <= dispGrp;
          lat[e]    <= dispLat;
          seqOf[e]  <= dispSeq;
          cnt[e]    <= '0;
          st[e]     <= (&dispRdyW) ? ST_READY : ST_WAIT;
        end else if (vld[e]) begin
          case (st[e])
            ST_WAIT: begin
              srcRdy[e] <= rdyNow[e];
              if (&rdyNow[e]) st[e] <= ST_READY;
            end
            ST_READY: begin
              if (strb.issueMask[e]) begin
                st[e]     <= ST_EXEC;
                cnt[e]    <= lat[e] - LAT_W'(1);
                unitOf[e] <= strb.issueUnit[e];
              end
            end
            default: begin
              if (cnt[e] == '0) vld[e] <= 1'b0;
              else              cnt[e] <= cnt[e] - LAT_W'(1);
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      readyMask[e] = vld[e] && (st[e] == ST_READY);
      execMask[e]  = vld[e] && (st[e] == ST_EXEC);
      doneMask[e]  = vld[e] && (st[e] == ST_EXEC) && (cnt[e] == '0);
    end
  end
  assign validMask = vld;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
    assert_ready_has_ops_R3: assert property (@(posedge clk) disable iff (!rstN)
      readyMask[e] |-> (&srcRdy[e]));
    assert_wb_frees_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
      doneMask[e] |=> !vld[e]);
    assert_issue_from_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
      strb.issueMask[e] |-> readyMask[e]);
  end
endmodule

// File: rtl/issq_ctrl.sv
module issq_ctrl
  import issq_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              dispValid,
  input  logic [ENTRIES-1:0]                validMask,
  input  logic [ENTRIES-1:0]                readyMask,
  input  logic [ENTRIES-1:0]                execMask,
  input  logic [ENTRIES-1:0][GRP_W-1:0]     grpOf,
  input  logic [ENTRIES-1:0][SEQ_W-1:0]     seqOf,
  input  logic [ENTRIES-1:0][UNIT_W-1:0]    unitOf,
  output strobes_t                          strb,
  output logic                              dispReady,
  output logic [IDX_W-1:0]                  dispIdx,
  output logic [SEQ_W-1:0]                  dispSeq,
  output logic [ISSUE_W-1:0]                issueValid,
  output logic [ISSUE_W-1:0][IDX_W-1:0]     issueIdx,
  output logic [ISSUE_W-1:0][UNIT_W-1:0]    issueUnit
);
  logic [GROUPS-1:0][UPG_W-1:0] ptrQ, ptrL;
  logic [UNITS-1:0]             busy, busyL;
  logic [ENTRIES-1:0]           taken;
  logic [SEQ_W-1:0]             seqQ;
  logic [IDX_W-1:0]             allocIdx;

  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  function automatic logic grpFree(input int g, input logic [UNITS-1:0] b);
    logic f;
    f = 1'b0;
    for (int k = 0; k < UNITS_PER_GRP; k++)
      if (!b[g*UNITS_PER_GRP + k]) f = 1'b1;
    return f;
  endfunction

  // lowest free slot takes the next dispatch
  always_comb begin
    allocIdx = '0;
    for (int e = ENTRIES-1; e >= 0; e--)
      if (!validMask[e]) allocIdx = IDX_W'(e);
  end
  assign dispReady = ~&validMask;
  assign dispIdx   = allocIdx;
  assign dispSeq   = seqQ;

  // oldest-first pick, round-robin unit choice per group
  always_comb begin
    int   g, uIdx, uSel, gu;
    logic found, got;
    logic [IDX_W-1:0] pick;
    busy = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (execMask[e]) busy[unitOf[e]] = 1'b1;
    busyL      = busy;
    ptrL       = ptrQ;
    taken      = '0;
    issueValid = '0;
    issueIdx   = '0;
    issueUnit  = '0;
    strb           = '0;
    strb.dispFire  = dispValid && dispReady;
    strb.allocIdx  = allocIdx;
    g = 0; uIdx = 0; uSel = 0; gu = 0; found = 1'b0; got = 1'b0; pick = '0;
    for (int s = 0; s < ISSUE_W; s++) begin
      found = 1'b0;
      pick  = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (readyMask[e] && !taken[e] && grpFree(int'(grpOf[e]), busyL) &&
            (!found || older(seqOf[e], seqOf[pick]))) begin
          pick  = IDX_W'(e);
          found = 1'b1;
        end
      end
      if (found) begin
        g    = int'(grpOf[pick]);
        got  = 1'b0;
        uSel = 0;
        for (int k = 0; k < UNITS_PER_GRP; k++) begin
          uIdx = (int'(ptrL[g]) + k) % UNITS_PER_GRP;
          if (!got && !busyL[g*UNITS_PER_GRP + uIdx]) begin
            got  = 1'b1;
            uSel = uIdx;
          end
        end
        gu                    = g*UNITS_PER_GRP + uSel;
        busyL[gu]             = 1'b1;
        ptrL[g]               = UPG_W'((uSel + 1) % UNITS_PER_GRP);
        taken[pick]           = 1'b1;
        issueValid[s]         = 1'b1;
        issueIdx[s]           = pick;
        issueUnit[s]          = UNIT_W'(gu);
        strb.issueMask[pick]  = 1'b1;
        strb.issueUnit[pick]  = UNIT_W'(gu);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
      seqQ <= '0;
    end else begin
      ptrQ <= ptrL;
      if (strb.dispFire) seqQ <= seqQ + SEQ_W'(1);
    end
  end

  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.dispFire |-> !validMask[strb.allocIdx]);
  assert_issue_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strb.issueMask) <= ISSUE_W);
  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    assert_unit_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
      issueValid[s] |-> !busy[issueUnit[s]]);
    assert_pick_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
      issueValid[s] |-> readyMask[issueIdx[s]]);
  end
endmodule

// File: rtl/issue_sched.sv
module issue_sched
  import issq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      dispValid,
  input  logic [SRCS*TAG_W-1:0]     dispTags,
  input  logic [SRCS-1:0]           dispSrcRdy,
  input  logic [GRP_W-1:0]          dispGrp,
  input  logic [LAT_W-1:0]          dispLat,
  input  logic                      wakeValid,
  input  logic [TAG_W-1:0]          wakeTag,
  output logic                      dispReady,
  output logic [IDX_W-1:0]          dispIdx,
  output logic [ISSUE_W-1:0]        issueValid,
  output logic [ISSUE_W*IDX_W-1:0]  issueIdx,
  output logic [ISSUE_W*UNIT_W-1:0] issueUnit,
  output logic [ENTRIES-1:0]        wbMask
);
  strobes_t                          strb;
  logic [ENTRIES-1:0]                validMask, readyMask, execMask, doneMask;
  logic [ENTRIES-1:0][GRP_W-1:0]     grpOf;
  logic [ENTRIES-1:0][SEQ_W-1:0]     seqOf;
  logic [ENTRIES-1:0][UNIT_W-1:0]    unitOf;
  logic [SEQ_W-1:0]                  dispSeq;
  logic [SRCS-1:0][TAG_W-1:0]        tagVec;
  logic [ISSUE_W-1:0][IDX_W-1:0]     idxVec;
  logic [ISSUE_W-1:0][UNIT_W-1:0]    unitVec;

  assign tagVec    = dispTags;
  assign issueIdx  = idxVec;
  assign issueUnit = unitVec;
  assign wbMask    = doneMask;

  issq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid),
    .validMask(validMask), .readyMask(readyMask), .execMask(execMask),
    .grpOf(grpOf), .seqOf(seqOf), .unitOf(unitOf),
    .strb(strb), .dispReady(dispReady), .dispIdx(dispIdx), .dispSeq(dispSeq),
    .issueValid(issueValid), .issueIdx(idxVec), .issueUnit(unitVec)
  );

  issq_entries u_entries (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dispTag(tagVec), .dispRdy(dispSrcRdy), .dispGrp(dispGrp),
    .dispLat(dispLat), .dispSeq(dispSeq),
    .wakeValid(wakeValid), .wakeTag(wakeTag),
    .validMask(validMask), .readyMask(readyMask), .execMask(execMask),
    .doneMask(doneMask), .grpOf(grpOf), .seqOf(seqOf), .unitOf(unitOf)
  );
endmodule

// File: tb/issue_sched_tb_top.sv
`timescale 1ns/1ps
module issue_sched_tb_top;
  import issq_pkg::*;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic                      dispValid = 1'b0;
  logic [SRCS*TAG_W-1:0]     dispTags = '0;
  logic [SRCS-1:0]           dispSrcRdy = '0;
  logic [GRP_W-1:0]          dispGrp = '0;
  logic [LAT_W-1:0]          dispLat = '0;
  logic                      wakeValid = 1'b0;
  logic [TAG_W-1:0]          wakeTag = '0;
  logic                      dispReady;
  logic [IDX_W-1:0]          dispIdx;
  logic [ISSUE_W-1:0]        issueValid;
  logic [ISSUE_W*IDX_W-1:0]  issueIdx;
  logic [ISSUE_W*UNIT_W-1:0] issueUnit;
  logic [ENTRIES-1:0]        wbMask;

  always #4 clk = ~clk;

  issue_sched dut_i (.*);

  int checkCnt = 0;
  int failCnt  = 0;

  // reference state
  bit mV [ENTRIES];
  int mSt [ENTRIES];           // 0 waiting, 1 eligible, 2 executing
  int mSeq [ENTRIES];
  int mTag [ENTRIES][SRCS];
  bit mRdy [ENTRIES][SRCS];
  int mGrp [ENTRIES];
  int mLat [ENTRIES];
  int mCnt [ENTRIES];
  int mUnit [ENTRIES];
  int mPtr [GROUPS];
  int mSeqCtr;

  // stimulus for the next cycle
  bit iDv; int iTag [SRCS]; bit iRdy [SRCS]; int iGrp; int iLat; bit iWv; int iWt;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit olderF(input int a, input int b);
    int d;
    d = (a - b) & ((1 << SEQ_W) - 1);
    return ((d >> (SEQ_W-1)) & 1) == 1;
  endfunction

  task automatic modelReset();
    for (int e = 0; e < ENTRIES; e++) begin mV[e] = 0; mSt[e] = 0; end
    for (int g = 0; g < GROUPS; g++) mPtr[g] = 0;
    mSeqCtr = 0;
  endtask

  task automatic cycle();
    bit busy [UNITS];
    bit taken [ENTRIES];
    bit expRdy; int expIdx; int expWb; int expCnt; int actCnt;
    bit eV [ISSUE_W]; int eIdx [ISSUE_W]; int eU [ISSUE_W];
    @(negedge clk);
    dispValid = iDv;
    for (int s = 0; s < SRCS; s++) begin
      dispTags[s*TAG_W +: TAG_W] = TAG_W'(iTag[s]);
      dispSrcRdy[s] = iRdy[s];
    end
    dispGrp = GRP_W'(iGrp); dispLat = LAT_W'(iLat);
    wakeValid = iWv; wakeTag = TAG_W'(iWt);
    #1;
    // R2: lowest free slot
    expRdy = 0; expIdx = 0;
    for (int e = ENTRIES-1; e >= 0; e--) if (!mV[e]) begin expRdy = 1; expIdx = e; end
    // R9: write-back flags
    expWb = 0;
    for (int e = 0; e < ENTRIES; e++)
      if (mV[e] && mSt[e] == 2 && mCnt[e] == 0) expWb |= (1 << e);
    for (int u = 0; u < UNITS; u++) busy[u] = 0;
    for (int e = 0; e < ENTRIES; e++) begin
      taken[e] = 0;
      if (mV[e] && mSt[e] == 2) busy[mUnit[e]] = 1;
    end
    expCnt = 0;
    for (int s = 0; s < ISSUE_W; s++) begin
      int pick; bit found;
      found = 0; pick = 0; eV[s] = 0; eIdx[s] = 0; eU[s] = 0;
      for (int e = 0; e < ENTRIES; e++) begin
        bit gf; gf = 0;
        for (int k = 0; k < UNITS_PER_GRP; k++) if (!busy[mGrp[e]*UNITS_PER_GRP+k]) gf = 1;
        if (mV[e] && mSt[e] == 1 && !taken[e] && gf && (!found || olderF(mSeq[e], mSeq[pick]))) begin
          pick = e; found = 1;
        end
      end
      if (found) begin
        int g, sel; bit got;
        g = mGrp[pick]; got = 0; sel = 0;
        for (int k = 0; k < UNITS_PER_GRP; k++) begin
          int u; u = (mPtr[g] + k) % UNITS_PER_GRP;
          if (!got && !busy[g*UNITS_PER_GRP+u]) begin got = 1; sel = u; end
        end
        busy[g*UNITS_PER_GRP+sel] = 1;
        mPtr[g] = (sel + 1) % UNITS_PER_GRP;
        taken[pick] = 1;
        eV[s] = 1; eIdx[s] = pick; eU[s] = g*UNITS_PER_GRP + sel;
        expCnt++;
      end
    end
    // compare
    check(dispReady == expRdy, "R2 dispReady", int'(dispReady), int'(expRdy));
    if (expRdy) check(int'(dispIdx) == expIdx, "R2 dispIdx", int'(dispIdx), expIdx);
    check(int'(wbMask) == expWb, "R9 wbMask", int'(wbMask), expWb);
    actCnt = $countones(issueValid);
    check(actCnt == expCnt, "R8 issue count", actCnt, expCnt);
    for (int s = 0; s < ISSUE_W; s++) begin
      check(issueValid[s] == eV[s], "R3 R4 R7 issueValid", int'(issueValid[s]), int'(eV[s]));
      if (eV[s] && issueValid[s]) begin
        check(int'(issueIdx[s*IDX_W +: IDX_W]) == eIdx[s], "R5 R10 issueIdx",
              int'(issueIdx[s*IDX_W +: IDX_W]), eIdx[s]);
        check(int'(issueUnit[s*UNIT_W +: UNIT_W]) == eU[s], "R6 issueUnit",
              int'(issueUnit[s*UNIT_W +: UNIT_W]), eU[s]);
      end
    end
    // advance reference state
    for (int e = 0; e < ENTRIES; e++) begin
      if (!mV[e]) continue;
      if (mSt[e] == 2) begin
        if (mCnt[e] == 0) mV[e] = 0; else mCnt[e]--;
      end else if (mSt[e] == 0) begin
        bit all; all = 1;
        for (int s = 0; s < SRCS; s++) begin
          if (iWv && mTag[e][s] == iWt) mRdy[e][s] = 1;
          if (!mRdy[e][s]) all = 0;
        end
        if (all) mSt[e] = 1;
      end else if (taken[e]) begin
        mSt[e] = 2; mCnt[e] = mLat[e] - 1;
        for (int s = 0; s < ISSUE_W; s++) if (eV[s] && eIdx[s] == e) mUnit[e] = eU[s];
      end
    end
    if (iDv && expRdy) begin
      bit all; all = 1;
      mV[expIdx] = 1;
      for (int s = 0; s < SRCS; s++) begin
        mTag[expIdx][s] = iTag[s];
        mRdy[expIdx][s] = iRdy[s] | (iWv && iTag[s] == iWt);
        if (!mRdy[expIdx][s]) all = 0;
      end
      mSt[expIdx] = all ? 1 : 0;
      mGrp[expIdx] = iGrp; mLat[expIdx] = iLat;
      mSeq[expIdx] = mSeqCtr;
      mSeqCtr = (mSeqCtr + 1) & ((1 << SEQ_W) - 1);
    end
  endtask

  task automatic randStim(input int pDisp, input int pRdy, input int pWake);
    iDv = ($urandom_range(99) < pDisp);
    for (int s = 0; s < SRCS; s++) begin
      iTag[s] = $urandom_range((1 << TAG_W) - 1);
      iRdy[s] = ($urandom_range(99) < pRdy);
    end
    iGrp = $urandom_range(GROUPS-1);
    iLat = $urandom_range((1 << LAT_W) - 1, 1);
    iWv  = ($urandom_range(99) < pWake);
    iWt  = $urandom_range((1 << TAG_W) - 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    iDv = 0; iGrp = 0; iLat = 1; iWv = 0; iWt = 0;
    for (int s = 0; s < SRCS; s++) begin iTag[s] = 0; iRdy[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state after reset
    check(dispReady == 1'b1, "R1 dispReady", int'(dispReady), 1);
    check(issueValid == '0, "R1 issueValid", int'(issueValid), 0);
    check(wbMask == '0, "R1 wbMask", int'(wbMask), 0);
    rstN = 1'b1;
    // fill with unready entries, two extra requests must be ignored (R2)
    for (int c = 0; c < ENTRIES + 2; c++) begin
      randStim(100, 0, 0);
      cycle();
    end
    // drain by sweeping every tag (R4, R10)
    for (int c = 0; c < 60; c++) begin
      randStim(0, 0, 100);
      iWt = c % (1 << TAG_W);
      cycle();
    end
    // contention on one group with long latency (R7, R6)
    for (int c = 0; c < 14; c++) begin
      randStim(100, 100, 0);
      iGrp = 0; iLat = (1 << LAT_W) - 1;
      cycle();
    end
    for (int c = 0; c < 80; c++) begin
      randStim(0, 0, 100);
      iWt = c % (1 << TAG_W);
      cycle();
    end
    // same-cycle wakeup at dispatch (R4)
    for (int c = 0; c < 4; c++) begin
      randStim(100, 0, 100);
      iWt = iTag[0];
      iTag[1] = iTag[0];
      cycle();
    end
    // mixed random traffic (R3, R5, R9)
    for (int c = 0; c < 4000; c++) begin
      randStim(60, 50, 70);
      cycle();
    end
    summary();
    $finish;
  end
endmodule